// File: doc/BRIEF.md
# Fetch and Paired-Load Access Checker

This block sits between a sequencing core and a single-ported word memory. It screens two kinds of request before they reach the memory: instruction fetches and double-word loads into a register pair. A fetch that is word-aligned and falls inside the configured memory size goes to the memory. One cycle later the word comes back on the fetch result port. A fetch that is not word-aligned, or that addresses bytes beyond the memory, stops the block for good: it enters a halted state that only reset leaves.

A paired load is checked first for an odd destination register and then for an effective address that is not 8-byte aligned. Either fault becomes a trap request, recorded as an 8-bit trap code in a pending-trap register. If the trap-enable input is low at that moment, the block halts instead. A clean paired load reads two consecutive words. The first word goes to the even register and the second to the odd register, in two back-to-back write cycles. In the second of these cycles the block returns the advanced program-counter pair. Trap vectoring and the memory contents belong to the surrounding logic.

The controller is a state machine with five states. ST_IDLE accepts requests and has `req_ready` high. ST_FETCH_WAIT returns the fetched word. ST_PAIR_LO writes the even register and reads the second word. ST_PAIR_HI writes the odd register and reports the program counters. ST_HALTED is terminal until reset. The transitions are:
- IDLE to FETCH_WAIT on a clean fetch.
- IDLE to PAIR_LO on a clean paired load.
- IDLE to HALTED on a faulting fetch, or on a paired-load fault while traps are disabled.
- IDLE to IDLE on a trapped paired load.
- FETCH_WAIT to IDLE.
- PAIR_LO to PAIR_HI.
- PAIR_HI to IDLE.

A fetch wins over a paired load presented in the same cycle.

Top module: `mem_access_checker`

## Requirements
- R1: After reset, `req_ready` is 1, `halted` is 0, `trap_pending` is 0 and `trap_code` is 0.
- R2: A fetch to an address whose low 2 bits are 00 and which lies below 2^MEM_BITS drives `fetch_done` high in the cycle after acceptance. `fetch_word` then equals memory word (address >> 2).
- R3: A fetch whose address has either of its low 2 bits set halts the block. No fetch result and no memory read follow.
- R4: A fetch whose address has any bit at or above position MEM_BITS set halts the block.
- R5: A paired load with an odd destination register and traps enabled sets `trap_pending` with `trap_code` = 0x02, one cycle after acceptance. No register write follows.
- R6: A paired load with an even destination and a nonzero value in effective-address bits [2:0], with traps enabled, sets `trap_pending` with `trap_code` = 0x07.
- R7: When the destination is odd and the address is also misaligned, the code recorded is 0x02. The odd-register check takes priority.
- R8: A clean paired load writes the word at (ea >> 2) to register rd in the first cycle after acceptance. In the next cycle it writes the word at (ea >> 2) + 1 to register rd + 1.
- R9: A clean paired load pulses `pc_update` in its second write cycle, with `next_pc` equal to the captured nPC and `next_npc` equal to nPC + 4. A trapped or halted load produces no `pc_update`.
- R10: A paired-load fault while `trap_en` is 0 halts the block and leaves `trap_code` and `trap_pending` unchanged.
- R11: `halted` stays high until reset. While halted, `req_ready` is 0 and requests produce no memory read, register write or fetch result.
- R12: `trap_clear` for one cycle returns `trap_pending` and `trap_code` to 0. `req_ready` is 0 during each cycle of an ongoing fetch or paired load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_ready | output | 1 | Block can accept a request this cycle |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| ldd_valid | input | 1 | Paired-load request |
| ldd_rd | input | RIDX_W | Paired-load destination register |
| ldd_ea | input | ADDR_W | Paired-load effective byte address |
| ldd_npc | input | ADDR_W | nPC value of the paired load |
| trap_en | input | 1 | Traps enabled (status register bit) |
| trap_clear | input | 1 | Consumer has taken the pending trap |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | MEM_BITS-2 | Memory word address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_req` |
| fetch_done | output | 1 | Fetch result valid |
| fetch_word | output | DATA_W | Fetched word |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RIDX_W | Register write index |
| rf_wdata | output | DATA_W | Register write data |
| pc_update | output | 1 | Program counters advance |
| next_pc | output | ADDR_W | New PC |
| next_npc | output | ADDR_W | New nPC |
| trap_pending | output | 1 | A trap request is recorded |
| trap_code | output | 8 | Recorded trap code |
| halted | output | 1 | Fatal halt, sticky until reset |

## Verification
The bench builds the block with MEM_BITS = 8, so the memory spans 256 bytes. This makes the out-of-range fetch reachable with a small address such as 0x100, and the top word 0xFC is the last legal one. The 32-bit address width and 5-bit register index stay at their defaults. This lets destinations 30/31 exercise the top register pair. With this set-up the bench covers both trap codes, their priority, the trap-disabled halt, and the return to service after each halt and reset.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_WAIT,
        ST_PAIR_LO,
        ST_PAIR_HI,
        ST_HALTED
    } mac_state_e;

    localparam int unsigned TRAP_NUM_ILLEGAL  = 32'h0000_0002;
    localparam int unsigned TRAP_NUM_MISALIGN = 32'h0000_0007;

    typedef struct packed {
        logic       fault;
        logic [7:0] code;
    } trap_req_t;

endpackage

// File: rtl/mac_fetch_chk.sv
module mac_fetch_chk #(
    parameter int ADDR_W   = 32,
    parameter int MEM_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned,
    output logic              out_of_range,
    output logic              bad
);
    assign misaligned = |addr[1:0];

    generate
        if (MEM_BITS >= ADDR_W) begin : g_full
            assign out_of_range = 1'b0;
        end else begin : g_part
            assign out_of_range = |addr[ADDR_W-1:MEM_BITS];
        end
    endgenerate

    assign bad = misaligned | out_of_range;
endmodule

// File: rtl/mac_pair_chk.sv
module mac_pair_chk
    import mac_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          RIDX_W   = 5,
    parameter int unsigned ILL_NUM  = TRAP_NUM_ILLEGAL,
    parameter int unsigned MIS_NUM  = TRAP_NUM_MISALIGN
) (
    input  logic [RIDX_W-1:0] rd,
    input  logic [2:0]        ea_low,
    output trap_req_t         req
);
    localparam logic [7:0] ILL_CODE = ILL_NUM[7:0];
    localparam logic [7:0] MIS_CODE = MIS_NUM[7:0];

    always_comb begin
        req = '0;
        if (rd[0]) begin
            req.fault = 1'b1;
            req.code  = ILL_CODE;
        end else if (|ea_low) begin
            req.fault = 1'b1;
            req.code  = MIS_CODE;
        end
    end
endmodule

// File: rtl/mac_trap_reg.sv
module mac_trap_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic [7:0] set_code,
    input  logic       clr,
    output logic       pending,
    output logic [7:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            code    <= 8'h00;
        end else if (set) begin
            pending <= 1'b1;
            code    <= set_code;
        end else if (clr) begin
            pending <= 1'b0;
            code    <= 8'h00;
        end
    end

    // R5
    trap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (pending && code == $past(set_code)));

    // R12
    trap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> (!pending && code == 8'h00));
endmodule

// File: rtl/mem_access_checker.sv
module mem_access_checker
    import mac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int RIDX_W   = 5,
    parameter int MEM_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  req_ready,
    input  logic                  fetch_valid,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  ldd_valid,
    input  logic [RIDX_W-1:0]     ldd_rd,
    input  logic [ADDR_W-1:0]     ldd_ea,
    input  logic [ADDR_W-1:0]     ldd_npc,
    input  logic                  trap_en,
    input  logic                  trap_clear,
    output logic                  mem_req,
    output logic [MEM_BITS-3:0]   mem_addr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  fetch_done,
    output logic [DATA_W-1:0]     fetch_word,
    output logic                  rf_we,
    output logic [RIDX_W-1:0]     rf_waddr,
    output logic [DATA_W-1:0]     rf_wdata,
    output logic                  pc_update,
    output logic [ADDR_W-1:0]     next_pc,
    output logic [ADDR_W-1:0]     next_npc,
    output logic                  trap_pending,
    output logic [7:0]            trap_code,
    output logic                  halted
);
    localparam int WORD_AW = MEM_BITS - 2;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    mac_state_e state_q, state_d;

    logic [WORD_AW-1:0] base_q;
    logic [RIDX_W-1:0]  rd_q;
    logic [ADDR_W-1:0]  npc_q;

    logic      fetch_mis, fetch_oor, fetch_bad;
    trap_req_t pair_req;
    logic      fetch_take, ldd_take;
    logic      trap_fire, halt_go, pair_go;

    mac_fetch_chk #(
        .ADDR_W   (ADDR_W),
        .MEM_BITS (MEM_BITS)
    ) u_fetch_chk (
        .addr         (fetch_addr),
        .misaligned   (fetch_mis),
        .out_of_range (fetch_oor),
        .bad          (fetch_bad)
    );

    mac_pair_chk #(
        .ADDR_W (ADDR_W),
        .RIDX_W (RIDX_W)
    ) u_pair_chk (
        .rd     (ldd_rd),
        .ea_low (ldd_ea[2:0]),
        .req    (pair_req)
    );

    mac_trap_reg u_trap_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (trap_fire),
        .set_code (pair_req.code),
        .clr      (trap_clear),
        .pending  (trap_pending),
        .code     (trap_code)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign halted     = (state_q == ST_HALTED);
    assign fetch_take = req_ready && fetch_valid;
    assign ldd_take   = req_ready && ldd_valid && !fetch_valid;
    assign trap_fire  = ldd_take && pair_req.fault && trap_en;
    assign pair_go    = ldd_take && !pair_req.fault;
    assign halt_go    = (fetch_take && fetch_bad) ||
                        (ldd_take && pair_req.fault && !trap_en);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            rd_q   <= '0;
            npc_q  <= '0;
        end else if (pair_go) begin
            base_q <= ldd_ea[MEM_BITS-1:2];
            rd_q   <= ldd_rd;
            npc_q  <= ldd_npc;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (halt_go)
                    state_d = ST_HALTED;
                else if (fetch_take)
                    state_d = ST_FETCH_WAIT;
                else if (pair_go)
                    state_d = ST_PAIR_LO;
            end
            ST_FETCH_WAIT: state_d = ST_IDLE;
            ST_PAIR_LO:    state_d = ST_PAIR_HI;
            ST_PAIR_HI:    state_d = ST_IDLE;
            ST_HALTED:     state_d = ST_HALTED;
            default:       state_d = ST_HALTED;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_addr   = '0;
        fetch_done = 1'b0;
        fetch_word = '0;
        rf_we      = 1'b0;
        rf_waddr   = '0;
        rf_wdata   = '0;
        pc_update  = 1'b0;
        next_pc    = '0;
        next_npc   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch_take && !fetch_bad) begin
                    mem_req  = 1'b1;
                    mem_addr = fetch_addr[MEM_BITS-1:2];
                end else if (pair_go) begin
                    mem_req  = 1'b1;
                    mem_addr = ldd_ea[MEM_BITS-1:2];
                end
            end
            ST_FETCH_WAIT: begin
                fetch_done = 1'b1;
                fetch_word = mem_rdata;
            end
            ST_PAIR_LO: begin
                rf_we    = 1'b1;
                rf_waddr = {rd_q[RIDX_W-1:1], 1'b0};
                rf_wdata = mem_rdata;
                mem_req  = 1'b1;
                mem_addr = base_q + WORD_AW'(1);
            end
            ST_PAIR_HI: begin
                rf_we     = 1'b1;
                rf_waddr  = {rd_q[RIDX_W-1:1], 1'b1};
                rf_wdata  = mem_rdata;
                pc_update = 1'b1;
                next_pc   = npc_q;
                next_npc  = npc_q + INSN_BYTES;
            end
            ST_HALTED: begin
            end
            default: begin
            end
        endcase
    end

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !rf_we && !fetch_done && !req_ready));

    // R3
    bad_fetch_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_take && fetch_mis) |-> !mem_req);

    // R4
    oor_fetch_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_take && fetch_oor) |=> halted);

    // R8
    odd_follows_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr[0]) |-> $past(rf_we && !rf_waddr[0]));

    // R9
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_update |-> (next_npc == next_pc + INSN_BYTES));

    // R10
    halt_keeps_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($stable(trap_code) && $stable(trap_pending)));
endmodule

// File: tb/mem_access_checker_tb_top.sv
module mem_access_checker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int MEM_BITS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_ready;
    logic fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic ldd_valid = 1'b0;
    logic [RIDX_W-1:0] ldd_rd = '0;
    logic [ADDR_W-1:0] ldd_ea = '0;
    logic [ADDR_W-1:0] ldd_npc = '0;
    logic trap_en = 1'b1;
    logic trap_clear = 1'b0;
    logic mem_req;
    logic [MEM_BITS-3:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic fetch_done;
    logic [DATA_W-1:0] fetch_word;
    logic rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic pc_update;
    logic [ADDR_W-1:0] next_pc, next_npc;
    logic trap_pending;
    logic [7:0] trap_code;
    logic halted;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;   // 0 fetch, 1 reg write, 2 pc update
        logic [31:0] a;
        logic [31:0] b;
        string       req;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_access_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W), .MEM_BITS(MEM_BITS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .ldd_valid(ldd_valid), .ldd_rd(ldd_rd), .ldd_ea(ldd_ea), .ldd_npc(ldd_npc),
        .trap_en(trap_en), .trap_clear(trap_clear),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .fetch_done(fetch_done), .fetch_word(fetch_word),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .pc_update(pc_update), .next_pc(next_pc), .next_npc(next_npc),
        .trap_pending(trap_pending), .trap_code(trap_code), .halted(halted)
    );

    function automatic logic [31:0] mem_word(int w);
        return 32'h5A00_0000 ^ (w * 32'h0001_0203);
    endfunction

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_word(int'(mem_addr));
    end

    function automatic void check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endfunction

    function automatic void push(int kind, logic [31:0] a, logic [31:0] b, string req);
        exp_t e;
        e.kind = kind; e.a = a; e.b = b; e.req = req;
        expq.push_back(e);
    endfunction

    function automatic void take(int kind, logic [31:0] a, logic [31:0] b, string what);
        exp_t e;
        if (expq.size() == 0) begin
            check(1'b0, {"unexpected ", what}, a, 32'hx);
            return;
        end
        e = expq.pop_front();
        check(e.kind == kind, e.req, 32'(kind), 32'(e.kind));
        if (e.kind == kind) begin
            check(a == e.a, e.req, a, e.a);
            check(b == e.b, e.req, b, e.b);
        end
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (fetch_done) take(0, 32'(fetch_word), 32'h0, "fetch");
            if (rf_we)      take(1, 32'(rf_waddr), rf_wdata, "reg write");
            if (pc_update)  take(2, next_pc, next_npc, "pc update");
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_fetch(logic [31:0] addr, bit good, string req);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = addr;
        if (good) push(0, mem_word(int'(addr >> 2)), 32'h0, req);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_ldd(logic [4:0] rd, logic [31:0] ea, logic [31:0] npc, bit good, string req);
        @(negedge clk);
        ldd_valid = 1'b1;
        ldd_rd = rd; ldd_ea = ea; ldd_npc = npc;
        if (good) begin
            push(1, {27'd0, rd[4:1], 1'b0}, mem_word(int'(ea >> 2)), "R8 even word");
            push(1, {27'd0, rd[4:1], 1'b1}, mem_word(int'(ea >> 2) + 1), "R8 odd word");
            push(2, npc, npc + 32'd4, "R9 pc advance");
        end
        @(posedge clk);
        #1 ldd_valid = 1'b0;
        @(negedge clk);
        if (good) check(req_ready == 1'b0, "R12 busy during pair", 32'(req_ready), 32'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_trap();
        @(negedge clk);
        trap_clear = 1'b1;
        @(negedge clk);
        trap_clear = 1'b0;
        check(trap_pending == 1'b0 && trap_code == 8'h00, "R12 trap clear",
              {23'd0, trap_pending, trap_code}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        check(halted === 1'b0, "R1 halted", 32'(halted), 32'h0);
        check(trap_pending === 1'b0, "R1 pending", 32'(trap_pending), 32'h0);
        check(trap_code === 8'h00, "R1 code", 32'(trap_code), 32'h0);

        // R2 clean fetches, incl. top word
        do_fetch(32'h10, 1'b1, "R2 fetch 0x10");
        do_fetch(32'hFC, 1'b1, "R2 fetch 0xFC");

        // R8 R9 clean pairs
        do_ldd(5'd4, 32'h20, 32'h100, 1'b1, "R8");
        do_ldd(5'd30, 32'hF8, 32'h2000_0004, 1'b1, "R8");
        check(expq.size() == 0, "R8 R9 all results seen", 32'(expq.size()), 32'h0);

        // R5 odd register
        do_ldd(5'd3, 32'h8, 32'h40, 1'b0, "R5");
        check(trap_pending && trap_code == 8'h02, "R5 illegal trap",
              {23'd0, trap_pending, trap_code}, 32'h102);
        check(halted == 1'b0, "R5 no halt", 32'(halted), 32'h0);
        clear_trap();

        // R6 misaligned
        do_ldd(5'd2, 32'h4, 32'h40, 1'b0, "R6");
        check(trap_pending && trap_code == 8'h07, "R6 misaligned 0x4",
              {23'd0, trap_pending, trap_code}, 32'h107);
        clear_trap();
        do_ldd(5'd2, 32'h2, 32'h40, 1'b0, "R6");
        check(trap_pending && trap_code == 8'h07, "R6 misaligned 0x2",
              {23'd0, trap_pending, trap_code}, 32'h107);
        clear_trap();

        // R7 priority
        do_ldd(5'd7, 32'h3, 32'h40, 1'b0, "R7");
        check(trap_pending && trap_code == 8'h02, "R7 priority",
              {23'd0, trap_pending, trap_code}, 32'h102);
        check(expq.size() == 0, "R9 no pc update on trap", 32'(expq.size()), 32'h0);

        // R10 trap while disabled (pending 0x02 kept)
        trap_en = 1'b0;
        do_ldd(5'd2, 32'h4, 32'h40, 1'b0, "R10");
        trap_en = 1'b1;
        check(halted == 1'b1, "R10 halt", 32'(halted), 32'h1);
        check(trap_pending && trap_code == 8'h02, "R10 trap kept",
              {23'd0, trap_pending, trap_code}, 32'h102);

        // R11 sticky, requests ignored
        do_fetch(32'h10, 1'b0, "R11");
        do_ldd(5'd4, 32'h20, 32'h100, 1'b0, "R11");
        check(halted == 1'b1, "R11 still halted", 32'(halted), 32'h1);
        check(req_ready == 1'b0, "R11 not ready", 32'(req_ready), 32'h0);

        // R3 misaligned fetch
        do_reset();
        do_fetch(32'h6, 1'b0, "R3");
        check(halted == 1'b1, "R3 misaligned fetch halts", 32'(halted), 32'h1);

        // R4 out of range fetch
        do_reset();
        do_fetch(32'h100, 1'b0, "R4");
        check(halted == 1'b1, "R4 range fetch halts", 32'(halted), 32'h1);

        do_reset();
        check(halted == 1'b0, "R11 reset leaves halt", 32'(halted), 32'h0);
        do_fetch(32'h40, 1'b1, "R2 fetch after reset");
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R2 queue drained", 32'(expq.size()), 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule